// File: doc/BRIEF.md
# Buffered Flash Program Sequencer

This block is the device-side engine of a flash factory-programming phase that works through a 32-word write buffer. The host issues plain bus writes. The first write of the phase fixes the start location and supplies the first word. Each later write supplies one more word, and the host keeps an address inside the same erase block on the bus. The device keeps its own running location, which starts at the start address and advances by one for each word. The offset wraps within the erase block.

When the buffer holds 32 words, the block stops accepting data. It then programs the words one at a time into a small register model of the flash array. After each word is programmed, the block reads it back and compares it with the buffered word. A word that does not match is programmed again, up to a fixed number of attempts. The array model behaves like flash: programming can only clear bits. When the buffer has been drained, the host may fill it again without a new command. A write to an address outside the start block ends the phase, and the block then sits in status-read mode until reset.

Top module: `bufProgSeq`

## Requirements
- R1: After reset, srReady is 1, srExit is 0 and srError is 0, and every array word reads 16'hFFFF.
- R2: The first accepted write of the phase records its address as the start location and programs its data word at that location.
- R3: The k-th word of the phase (k counted from 0) goes to the location whose block bits equal those of the start address and whose low BLOCK_W bits are (start offset + k) modulo 2^BLOCK_W. The exact address on the bus has no effect, provided it lies in the start block.
- R4: After the 32nd word of a fill is accepted, srReady is 0 from the next cycle until all 32 words are programmed and verified. srReady then returns to 1, and the next fill continues the location sequence with no new command.
- R5: Programming a location stores (old value AND data). A word of 16'hFFFF therefore leaves an erased location at 16'hFFFF.
- R6: Each programmed word is read back and compared with the buffered word. On a mismatch it is programmed again, up to MAX_TRY attempts in total. If the word still fails after the last attempt, srError becomes 1 and stays 1 until reset.
- R7: An accepted write whose address bits above BLOCK_W differ from those of the start address ends the phase. srExit becomes 1, srReady is 1, and any words already in a partly filled buffer are discarded without reaching the array.
- R8: Once srExit is 1, it stays 1 until reset, and all further writes are ignored: the array and the status outputs do not change.
- R9: A write presented while srReady is 0 is ignored. This holds even for an out-of-block address: it neither ends the phase nor changes any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe, one word per cycle it is high |
| wrAddr | input | ADDR_W | Host write address |
| wrData | input | DATA_W | Host write data |
| rdAddr | input | ADDR_W | Array read address |
| rdData | output | DATA_W | Array word at rdAddr, combinational |
| srReady | output | 1 | Ready for the next word |
| srExit | output | 1 | Phase has ended, status-read mode |
| srError | output | 1 | A word failed verify after all attempts |

## Verification
The assertions assume a host that follows the handshake. It writes only while srReady is 1, or, if it writes while busy, it expects that write to be dropped. They also assume that rdAddr is held steady whenever the array is expected to stay frozen after exit.

The stimulus polls srReady between fills and never depends on a write made during busy cycles. It draws in-block addresses and data from a fixed seed, and it builds mismatching rewrites only by wrapping a later fill onto words the phase has already programmed.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef struct packed {
    logic latchStart;   // capture start address and offset
    logic bufWrite;     // store wrData into buffer slot idx
    logic arrWrite;     // program buffer slot idx into array
    logic advBase;      // move running offset past the drained fill
  } bpsStrobe_t;
endpackage

// File: rtl/bps_datapath.sv
module bps_datapath
  import bps_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BLOCK_W   = 6,
  parameter int BUF_DEPTH = 32,
  parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpsStrobe_t        stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              sameBlock,
  output logic              verifyOk
);
  localparam int ARR_WORDS = 1 << ADDR_W;
  localparam int HI_W      = ADDR_W - BLOCK_W;

  logic [DATA_W-1:0]  bufMem [BUF_DEPTH];
  logic [DATA_W-1:0]  arr    [ARR_WORDS];
  logic [HI_W-1:0]    startHi;
  logic [BLOCK_W-1:0] baseOff;
  logic [BLOCK_W-1:0] curOff;
  logic [ADDR_W-1:0]  loc;

  assign curOff    = baseOff + BLOCK_W'(idx);
  assign loc       = {startHi, curOff};
  assign sameBlock = (wrAddr[ADDR_W-1:BLOCK_W] == startHi);
  assign verifyOk  = (arr[loc] == bufMem[idx]);
  assign rdData    = arr[rdAddr];

  always_ff @(posedge clk) begin
    if (stb.bufWrite) bufMem[idx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startHi <= '0;
      baseOff <= '0;
    end else if (stb.latchStart) begin
      startHi <= wrAddr[ADDR_W-1:BLOCK_W];
      baseOff <= wrAddr[BLOCK_W-1:0];
    end else if (stb.advBase) begin
      baseOff <= baseOff + BLOCK_W'(BUF_DEPTH);
    end
  end

  // flash-like array model: programming can only clear bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ARR_WORDS; i++) arr[i] <= '1;
    end else if (stb.arrWrite) begin
      arr[loc] <= arr[loc] & bufMem[idx];
    end
  end
endmodule

// File: rtl/bps_control.sv
module bps_control
  import bps_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int MAX_TRY   = 3,
  parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             sameBlock,
  input  logic             verifyOk,
  output bpsStrobe_t       stb,
  output logic [IDX_W-1:0] idx,
  output logic             srReady,
  output logic             srExit,
  output logic             srError
);
  localparam int TRY_W = $clog2(MAX_TRY + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BUF_DEPTH - 1);

  typedef enum logic [1:0] {FILL, PROG, VERIFY, DONE} state_t;

  state_t           state;
  logic             started;
  logic [TRY_W-1:0] tries;
  logic             lastTry;

  assign lastTry = (tries == TRY_W'(MAX_TRY));

  always_comb begin
    stb = '0;
    if (state == FILL && wrEn) begin
      stb.latchStart = !started;
      stb.bufWrite   = !started || sameBlock;
    end
    stb.arrWrite = (state == PROG);
    stb.advBase  = (state == VERIFY) && (verifyOk || lastTry) && (idx == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= FILL;
      started <= 1'b0;
      idx     <= '0;
      tries   <= '0;
      srError <= 1'b0;
    end else begin
      unique case (state)
        FILL: if (wrEn) begin
          if (!started) begin
            started <= 1'b1;
            idx     <= IDX_W'(1);
          end else if (!sameBlock) begin
            state <= DONE;
            idx   <= '0;
          end else if (idx == LAST) begin
            state <= PROG;
            idx   <= '0;
            tries <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        PROG: begin
          tries <= tries + TRY_W'(1);
          state <= VERIFY;
        end
        VERIFY: begin
          if (verifyOk || lastTry) begin
            if (!verifyOk) srError <= 1'b1;
            tries <= '0;
            if (idx == LAST) begin
              state <= FILL;
              idx   <= '0;
            end else begin
              state <= PROG;
              idx   <= idx + IDX_W'(1);
            end
          end else begin
            state <= PROG;
          end
        end
        DONE: ;
        default: state <= FILL;
      endcase
    end
  end

  assign srReady = (state == FILL) || (state == DONE);
  assign srExit  = (state == DONE);
endmodule

// File: rtl/bufProgSeq.sv
module bufProgSeq
  import bps_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BLOCK_W   = 6,
  parameter int BUF_DEPTH = 32,
  parameter int MAX_TRY   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              srReady,
  output logic              srExit,
  output logic              srError
);
  localparam int IDX_W = $clog2(BUF_DEPTH);

  bpsStrobe_t       stb;
  logic [IDX_W-1:0] idx;
  logic             sameBlock;
  logic             verifyOk;

  bps_control #(.BUF_DEPTH(BUF_DEPTH), .MAX_TRY(MAX_TRY), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .sameBlock(sameBlock), .verifyOk(verifyOk),
    .stb(stb), .idx(idx), .srReady(srReady), .srExit(srExit), .srError(srError)
  );

  bps_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLOCK_W(BLOCK_W),
                 .BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(idx), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .sameBlock(sameBlock), .verifyOk(verifyOk)
  );
endmodule

// File: rtl/bufProgSeq_chk.sv
module bufProgSeq_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              srReady,
  input logic              srExit,
  input logic              srError,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData
);
  a_r8_exit_sticky: assert property (@(posedge clk) disable iff (!rstN)
    srExit |=> srExit);

  a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    srError |=> srError);

  a_r7_exit_ready: assert property (@(posedge clk) disable iff (!rstN)
    srExit |-> srReady);

  a_r4_busy_not_exited: assert property (@(posedge clk) disable iff (!rstN)
    !srReady |-> !srExit);

  a_r8_array_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ($past(srExit) && srExit && $stable(rdAddr)) |-> $stable(rdData));
endmodule

bind bufProgSeq bufProgSeq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .srReady(srReady), .srExit(srExit),
  .srError(srError), .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/bufProgSeq_tb.sv
module bufProgSeq_tb;
  localparam int AW = 8, DW = 16, BW = 6, NB = 32;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [DW-1:0] wrData = '0, rdData;
  logic srReady, srExit, srError;

  int nVec = 0, nBad = 0;

  // reference model
  logic [DW-1:0] mArr [1<<AW];
  logic [DW-1:0] mBuf [NB];
  logic [AW-1:0] mStart;
  logic [BW-1:0] mOff;
  int  mCnt;
  bit  mStarted, mExit, mErr;

  always #4 clk = ~clk;

  bufProgSeq u_dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .srReady(srReady), .srExit(srExit), .srError(srError));

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] locOf(int k);
    logic [BW-1:0] o = mOff + BW'(k);
    return {mStart[AW-1:BW], o};
  endfunction

  function automatic void commitFill();
    for (int k = 0; k < NB; k++) begin
      logic [AW-1:0] a = locOf(k);
      logic [DW-1:0] v = mArr[a] & mBuf[k];
      if (v != mBuf[k]) mErr = 1;
      mArr[a] = v;
    end
    mOff = mOff + BW'(NB);
    mCnt = 0;
  endfunction

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < (1<<AW); i++) mArr[i] = '1;
    mStarted = 0; mExit = 0; mErr = 0; mCnt = 0; mOff = '0; mStart = '0;
  endtask

  task automatic rawWrite(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic hostWrite(logic [AW-1:0] a, logic [DW-1:0] d);
    if (!mExit) begin
      if (!mStarted) begin
        mStarted = 1; mStart = a; mOff = a[BW-1:0]; mBuf[0] = d; mCnt = 1;
      end else if (a[AW-1:BW] != mStart[AW-1:BW]) begin
        mExit = 1; mCnt = 0;
      end else begin
        mBuf[mCnt] = d; mCnt++;
        if (mCnt == NB) commitFill();
      end
    end
    rawWrite(a, d);
  endtask

  task automatic waitReady(string req);
    int n = 0;
    while (!srReady && n < 400) begin @(negedge clk); n++; end
    check(srReady == 1'b1, req, 32'(srReady), 32'd1);
  endtask

  task automatic scanArray(string req);
    int bad = 0;
    for (int a = 0; a < (1<<AW); a++) begin
      @(negedge clk); rdAddr = AW'(a); #1;
      if (rdData !== mArr[a]) begin
        bad++;
        if (bad < 4) check(1'b0, req, 32'(rdData), 32'(mArr[a]));
      end
    end
    check(bad == 0, req, 32'(bad), 32'd0);
  endtask

  task automatic checkStatus(string req);
    check(srReady == 1'b1, req, 32'(srReady), 32'd1);
    check(srExit == mExit, req, 32'(srExit), 32'(mExit));
    check(srError == mErr, req, 32'(srError), 32'(mErr));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    int unused = $urandom(32'h5EED);
    logic [DW-1:0] d;

    // ---------- phase 1 ----------
    doReset();
    @(negedge clk);
    checkStatus("R1 reset status");
    scanArray("R1 erased array");

    // fill 1: start 0x45, host keeps start address; some FFFF slots
    for (int k = 0; k < NB; k++) begin
      d = (k % 7 == 3) ? 16'hFFFF : DW'($urandom);
      hostWrite(8'h45, d);
    end
    check(srReady == 1'b0, "R4 busy after 32nd word", 32'(srReady), 32'd0);
    rawWrite(8'h00, 16'h0000);  // R9: dropped while busy
    waitReady("R4 ready after drain");
    checkStatus("R9 busy write ignored");
    scanArray("R2 R3 R5 fill one");

    // fill 2: random in-block addresses, offset wraps inside the block
    for (int k = 0; k < NB; k++)
      hostWrite({2'b01, 6'($urandom)}, DW'($urandom));
    waitReady("R4 second fill without command");
    checkStatus("R3 second fill status");
    scanArray("R3 wrap within block");

    // partial fill then out-of-block termination
    for (int k = 0; k < 10; k++) hostWrite(8'h45, DW'($urandom));
    hostWrite(8'hC3, 16'h1234);
    @(negedge clk);
    checkStatus("R7 terminated");
    check(srExit == 1'b1, "R7 exit flag", 32'(srExit), 32'd1);
    scanArray("R7 partial buffer discarded");

    // writes after exit
    hostWrite(8'h45, 16'h0000);
    hostWrite(8'h00, 16'h0000);
    @(negedge clk);
    checkStatus("R8 exit sticky");
    scanArray("R8 writes ignored after exit");

    // ---------- phase 2: verify failure ----------
    doReset();
    @(negedge clk);
    checkStatus("R1 reset clears exit");
    for (int k = 0; k < NB; k++)
      hostWrite(8'h80, (k == 0) ? 16'h00FF : DW'($urandom));
    waitReady("R4 phase two fill one");
    for (int k = 0; k < NB; k++) hostWrite(8'h80, 16'hFFFF);
    waitReady("R5 FFFF fill");
    check(srError == 1'b0, "R6 no error before conflict", 32'(srError), 32'd0);
    // third fill wraps onto programmed words; word 0 asks to set bits
    for (int k = 0; k < NB; k++)
      hostWrite(8'h80, (k == 0) ? 16'h0FFF : mArr[{2'b10, 6'(k)}]);
    waitReady("R6 drained after retries");
    check(srError == 1'b1, "R6 error set", 32'(srError), 32'd1);
    checkStatus("R6 status");
    scanArray("R6 array after failed verify");
    hostWrite(8'h40, 16'h0000);
    @(negedge clk);
    check(srError == 1'b1, "R6 error sticky", 32'(srError), 32'd1);
    checkStatus("R7 exit after error");

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule